// File: doc/BRIEF.md
# SDRAM Command and Mask Sequencer

This block sits on the controller side of one rank of 64Mb x8 synchronous DRAM with four banks. A request port takes one request per cycle: activate, read, write, precharge of one bank, precharge of every bank, load-mode, power-down entry and power-down exit. Each request carries a bank, a row, a column, an auto-precharge flag, a mode word and a per-beat mask. The block turns each legal request into a registered pin pattern on chip select, the three strobes, the bank pins and the twelve address pins. Address bit 10 carries either a row bit, the auto-precharge flag or the all-bank select, depending on the command. Because every pin comes from a flop, it is stable at the rising edge where the memory samples it.

The block keeps an open flag and an open-row register for each bank. It refuses a request that would break the bank state: an activate to an open bank, or a read or write to a closed bank or to a row that is not the open one. A refused request produces a one-cycle error pulse and a deselect on the bus. The block also times the mask pin itself. For write beats, the mask lines up with the data beat. For read beats, it leads the beat by two cycles, so the outputs go high-Z on the masked beat. Clock enable is driven low for power-down and high again on exit.

Top module: `sdram_cmd_seq`

## Requirements
- R1: After reset, chip select, RAS#, CAS# and WE# are all high, clock enable is high, the mask pin and the error output are low, and every bank counts as closed, so a read to any bank is refused.
- R2: Outputs are registered. An accepted request sampled at a rising edge shows on the pins from that edge for one cycle. In a cycle with no accepted command, the bus is a deselect: chip select and the three strobes are high, and the bank and address pins are zero.
- R3: With chip select low, {RAS#,CAS#,WE#} is 011 for activate, 101 for read, 100 for write, 010 for both precharge kinds and 000 for load-mode. An activate drives the bank on BA[1:0] and the full 12-bit row on A[11:0], including A10.
- R4: A read or write drives the bank on BA, the 9-bit column on A[8:0], the auto-precharge flag on A10, and zero on A9 and A11. With auto-precharge set, that bank counts as closed from then on.
- R5: Precharge of one bank drives A10 low, the bank on BA and zero elsewhere, and closes that bank. Precharge of all banks drives A10 high, with BA and the other address bits zero, and closes every bank. Load-mode drives the 12-bit mode word on A[11:0] with BA zero.
- R6: An activate to an open bank, or a read or write to a closed bank or with a row other than that bank's open row, is refused. The error output goes high for one cycle, the bus shows a deselect, and the bank state does not change.
- R7: For an accepted write with mask bit i set (bit 0 is the first beat), the mask pin is high exactly i cycles after the cycle in which the write command is on the pins. With no masked beat pending, the mask pin is low.
- R8: For an accepted read with mask bit i set, the mask pin is high exactly CL-2+i cycles after the read command cycle (CL is the CAS latency parameter, default 3; burst length default 4). This is two cycles ahead of beat i.
- R9: Op codes are 0 activate, 1 read, 2 write, 3 precharge one, 4 precharge all, 5 load-mode, 6 power-down entry, 7 power-down exit. An accepted entry drives clock enable low from the next edge, with a deselect bus. While clock enable is low, every request except exit is refused with an error. An accepted exit raises clock enable. An exit while powered up is refused with an error.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | A request is present this cycle |
| req_op | input | 3 | Request op code (see R9) |
| req_bank | input | 2 | Target bank |
| req_row | input | 12 | Row for activate; expected open row for read and write |
| req_col | input | 9 | Column for read and write |
| req_ap | input | 1 | Auto-precharge with read or write |
| req_mode | input | 12 | Mode word for load-mode |
| req_bmask | input | BL | Per-beat mask, bit 0 first beat |
| sd_cke | output | 1 | Clock enable to the memory |
| sd_cs_n | output | 1 | Chip select, active low |
| sd_ras_n | output | 1 | Row strobe, active low |
| sd_cas_n | output | 1 | Column strobe, active low |
| sd_we_n | output | 1 | Write enable, active low |
| sd_ba | output | 2 | Bank select |
| sd_addr | output | 12 | Address and op-code pins |
| sd_dqm | output | 1 | Data mask / read output disable |
| req_err | output | 1 | One-cycle pulse for a refused request |

## Verification
The assertions assume that the op code is one of the eight listed values whenever req_valid is high. They also assume that the requester never issues a read or write whose mask window runs into a power-down: the mask pipe keeps shifting while clock enable is low. The stimulus drives only those op codes from a task and keeps a gap of idle cycles before power-down entry. It also drives refused requests on purpose, so the hold-state and deselect properties see both outcomes.

// File: rtl/sdram_seq_pkg.sv
package sdram_seq_pkg;

    localparam int NUM_BANKS = 4;
    localparam int BA_W      = $clog2(NUM_BANKS);
    localparam int ROW_W     = 12;
    localparam int COL_W     = 9;
    localparam int ADDR_W    = 12;
    localparam int AP_BIT    = 10;

    typedef enum logic [2:0] {
        OP_ACT  = 3'd0,
        OP_RD   = 3'd1,
        OP_WR   = 3'd2,
        OP_PRE  = 3'd3,
        OP_PREA = 3'd4,
        OP_LMR  = 3'd5,
        OP_PDE  = 3'd6,
        OP_PDX  = 3'd7
    } req_op_e;

    typedef struct packed {
        logic              cs_n;
        logic              ras_n;
        logic              cas_n;
        logic              we_n;
        logic [BA_W-1:0]   ba;
        logic [ADDR_W-1:0] addr;
    } pin_bus_t;

    localparam pin_bus_t BUS_IDLE = '{cs_n: 1'b1, ras_n: 1'b1, cas_n: 1'b1,
                                      we_n: 1'b1, ba: '0, addr: '0};

endpackage

// File: rtl/sdram_bank_track.sv
module sdram_bank_track
    import sdram_seq_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req_valid,
    input  req_op_e          req_op,
    input  logic [BA_W-1:0]  req_bank,
    input  logic [ROW_W-1:0] req_row,
    input  logic             req_ap,
    output logic             accept,
    output logic             reject,
    output logic             cke
);

    typedef struct packed {
        logic [NUM_BANKS-1:0]            open;
        logic [NUM_BANKS-1:0][ROW_W-1:0] row;
        logic                            pd;
    } trk_t;

    trk_t trk_d, trk_q;
    logic legal;

    always_comb begin
        trk_d = trk_q;
        legal = 1'b0;
        case (req_op)
            OP_ACT:         legal = !trk_q.pd && !trk_q.open[req_bank];
            OP_RD, OP_WR:   legal = !trk_q.pd && trk_q.open[req_bank] &&
                                    (trk_q.row[req_bank] == req_row);
            OP_PRE, OP_PREA,
            OP_LMR, OP_PDE: legal = !trk_q.pd;
            OP_PDX:         legal = trk_q.pd;
            default:        legal = 1'b0;
        endcase
        accept = req_valid && legal;
        reject = req_valid && !legal;
        if (accept) begin
            case (req_op)
                OP_ACT: begin
                    trk_d.open[req_bank] = 1'b1;
                    trk_d.row[req_bank]  = req_row;
                end
                OP_RD, OP_WR: begin
                    if (req_ap) trk_d.open[req_bank] = 1'b0;
                end
                OP_PRE:  trk_d.open[req_bank] = 1'b0;
                OP_PREA: trk_d.open = '0;
                OP_PDE:  trk_d.pd = 1'b1;
                OP_PDX:  trk_d.pd = 1'b0;
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) trk_q <= '0;
        else        trk_q <= trk_d;
    end

    assign cke = !trk_q.pd;

    // R6: an accepted activate leaves its bank open in the next cycle
    p_act_opens_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && req_op == OP_ACT) |=> trk_q.open[$past(req_bank)]);

    // R6: a refused request leaves the bank state untouched
    p_reject_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        reject |=> ($stable(trk_q.open) && $stable(trk_q.row)));

    // R9: power-down only starts from an entry request
    p_pd_entry_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(trk_q.pd) |-> $past(req_valid && req_op == OP_PDE));

endmodule

// File: rtl/sdram_cmd_enc.sv
module sdram_cmd_enc
    import sdram_seq_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             accept,
    input  logic             reject,
    input  req_op_e          req_op,
    input  logic [BA_W-1:0]  req_bank,
    input  logic [ROW_W-1:0] req_row,
    input  logic [COL_W-1:0] req_col,
    input  logic             req_ap,
    input  logic [ADDR_W-1:0] req_mode,
    output pin_bus_t         bus,
    output logic             err
);

    typedef struct packed {
        pin_bus_t bus;
        logic     err;
    } enc_t;

    enc_t enc_d, enc_q;

    always_comb begin
        enc_d.bus = BUS_IDLE;
        enc_d.err = reject;
        if (accept) begin
            case (req_op)
                OP_ACT: begin
                    enc_d.bus.cs_n  = 1'b0;
                    enc_d.bus.ras_n = 1'b0;
                    enc_d.bus.ba    = req_bank;
                    enc_d.bus.addr  = ADDR_W'(req_row);
                end
                OP_RD, OP_WR: begin
                    enc_d.bus.cs_n  = 1'b0;
                    enc_d.bus.cas_n = 1'b0;
                    enc_d.bus.we_n  = (req_op == OP_RD);
                    enc_d.bus.ba    = req_bank;
                    enc_d.bus.addr[COL_W-1:0] = req_col;
                    enc_d.bus.addr[AP_BIT]    = req_ap;
                end
                OP_PRE, OP_PREA: begin
                    enc_d.bus.cs_n  = 1'b0;
                    enc_d.bus.ras_n = 1'b0;
                    enc_d.bus.we_n  = 1'b0;
                    if (req_op == OP_PRE) enc_d.bus.ba = req_bank;
                    else                  enc_d.bus.addr[AP_BIT] = 1'b1;
                end
                OP_LMR: begin
                    enc_d.bus.cs_n  = 1'b0;
                    enc_d.bus.ras_n = 1'b0;
                    enc_d.bus.cas_n = 1'b0;
                    enc_d.bus.we_n  = 1'b0;
                    enc_d.bus.addr  = req_mode;
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) enc_q <= '{bus: BUS_IDLE, err: 1'b0};
        else        enc_q <= enc_d;
    end

    assign bus = enc_q.bus;
    assign err = enc_q.err;

endmodule

// File: rtl/sdram_dqm_gen.sv
module sdram_dqm_gen #(
    parameter int BL = 4,
    parameter int CL = 3
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load_wr,
    input  logic          load_rd,
    input  logic [BL-1:0] bmask,
    output logic          dqm
);

    localparam int LEAD  = CL - 2;
    localparam int DEPTH = LEAD + BL;

    typedef struct packed {
        logic             dqm;
        logic [DEPTH-1:0] pipe;
    } msk_t;

    msk_t msk_d, msk_q;
    logic [DEPTH:0] fresh;

    always_comb begin
        fresh = '0;
        for (int i = 0; i < BL; i++) begin
            fresh[i]        = fresh[i] | (load_wr & bmask[i]);
            fresh[LEAD + i] = fresh[LEAD + i] | (load_rd & bmask[i]);
        end
        msk_d.dqm = msk_q.pipe[0] | fresh[0];
        for (int k = 0; k < DEPTH; k++) begin
            if (k + 1 < DEPTH) msk_d.pipe[k] = msk_q.pipe[k + 1] | fresh[k + 1];
            else               msk_d.pipe[k] = fresh[k + 1];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) msk_q <= '0;
        else        msk_q <= msk_d;
    end

    assign dqm = msk_q.dqm;

    // R7: with nothing scheduled and nothing loading, the mask stays low
    p_dqm_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (msk_q.pipe == '0 && !load_wr && !load_rd) |=> !msk_q.dqm);

endmodule

// File: rtl/sdram_cmd_seq.sv
module sdram_cmd_seq
    import sdram_seq_pkg::*;
#(
    parameter int BL = 4,
    parameter int CL = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic [2:0]        req_op,
    input  logic [BA_W-1:0]   req_bank,
    input  logic [ROW_W-1:0]  req_row,
    input  logic [COL_W-1:0]  req_col,
    input  logic              req_ap,
    input  logic [ADDR_W-1:0] req_mode,
    input  logic [BL-1:0]     req_bmask,
    output logic              sd_cke,
    output logic              sd_cs_n,
    output logic              sd_ras_n,
    output logic              sd_cas_n,
    output logic              sd_we_n,
    output logic [BA_W-1:0]   sd_ba,
    output logic [ADDR_W-1:0] sd_addr,
    output logic              sd_dqm,
    output logic              req_err
);

    req_op_e  op;
    logic     accept, reject;
    pin_bus_t bus;

    assign op = req_op_e'(req_op);

    sdram_bank_track i_track (
        .clk       (clk),
        .rst_n     (rst_n),
        .req_valid (req_valid),
        .req_op    (op),
        .req_bank  (req_bank),
        .req_row   (req_row),
        .req_ap    (req_ap),
        .accept    (accept),
        .reject    (reject),
        .cke       (sd_cke)
    );

    sdram_cmd_enc i_enc (
        .clk      (clk),
        .rst_n    (rst_n),
        .accept   (accept),
        .reject   (reject),
        .req_op   (op),
        .req_bank (req_bank),
        .req_row  (req_row),
        .req_col  (req_col),
        .req_ap   (req_ap),
        .req_mode (req_mode),
        .bus      (bus),
        .err      (req_err)
    );

    sdram_dqm_gen #(.BL(BL), .CL(CL)) i_dqm (
        .clk     (clk),
        .rst_n   (rst_n),
        .load_wr (accept && op == OP_WR),
        .load_rd (accept && op == OP_RD),
        .bmask   (req_bmask),
        .dqm     (sd_dqm)
    );

    assign sd_cs_n  = bus.cs_n;
    assign sd_ras_n = bus.ras_n;
    assign sd_cas_n = bus.cas_n;
    assign sd_we_n  = bus.we_n;
    assign sd_ba    = bus.ba;
    assign sd_addr  = bus.addr;

    // R6: a refused request never reaches the memory as a command
    p_err_deselect_r6: assert property (@(posedge clk) disable iff (!rst_n)
        req_err |-> sd_cs_n);

    // R9: no command is issued while the memory clock is suspended
    p_pd_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !sd_cke |-> sd_cs_n);

endmodule

// File: tb/test_sdram_cmd_seq.sv
module test_sdram_cmd_seq;

    localparam int BL = 4;
    localparam int CL = 3;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic [2:0]  req_op = 3'd0;
    logic [1:0]  req_bank = 2'd0;
    logic [11:0] req_row = 12'd0;
    logic [8:0]  req_col = 9'd0;
    logic        req_ap = 1'b0;
    logic [11:0] req_mode = 12'd0;
    logic [3:0]  req_bmask = 4'd0;
    logic        sd_cke, sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n, sd_dqm, req_err;
    logic [1:0]  sd_ba;
    logic [11:0] sd_addr;

    sdram_cmd_seq #(.BL(BL), .CL(CL)) i_sdram_cmd_seq (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_op(req_op),
        .req_bank(req_bank), .req_row(req_row), .req_col(req_col),
        .req_ap(req_ap), .req_mode(req_mode), .req_bmask(req_bmask),
        .sd_cke(sd_cke), .sd_cs_n(sd_cs_n), .sd_ras_n(sd_ras_n),
        .sd_cas_n(sd_cas_n), .sd_we_n(sd_we_n), .sd_ba(sd_ba),
        .sd_addr(sd_addr), .sd_dqm(sd_dqm), .req_err(req_err)
    );

    always #10 clk = ~clk;

    typedef struct {
        int          cyc;
        logic [3:0]  cmd;
        logic [1:0]  ba;
        logic [11:0] addr;
        logic        err;
        string       tag;
    } exp_t;

    exp_t  sb[$];
    int    tests = 0;
    int    fails = 0;
    int    cyc = 0;
    bit    mon_on = 1'b0;
    bit    exp_dqm [0:2047];
    string dqm_tag [0:2047];

    logic        m_open [4];
    logic [11:0] m_row [4];
    logic        m_pd = 1'b0;
    logic        m_cke = 1'b1;

    always @(posedge clk) cyc <= cyc + 1;

    task automatic chk(input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s at cycle %0d: actual=%h expected=%h",
                     tag, what, cyc, act, exp);
        end
    endtask

    // monitor: pops the scoreboard in the cycle each item is due
    initial begin
        forever begin
            @(posedge clk);
            #5;
            if (mon_on) begin
                exp_t e;
                if (sb.size() > 0 && sb[0].cyc == cyc) e = sb.pop_front();
                else e = '{cyc: cyc, cmd: 4'hF, ba: 2'd0, addr: 12'd0,
                           err: 1'b0, tag: "R2"};
                chk(e.tag, "cmd", {28'd0, sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n},
                    {28'd0, e.cmd});
                chk(e.tag, "ba", {30'd0, sd_ba}, {30'd0, e.ba});
                chk(e.tag, "addr", {20'd0, sd_addr}, {20'd0, e.addr});
                chk(e.tag, "err", {31'd0, req_err}, {31'd0, e.err});
                chk("R9", "cke", {31'd0, sd_cke}, {31'd0, m_cke});
                chk(exp_dqm[cyc] ? dqm_tag[cyc] : "R7", "dqm",
                    {31'd0, sd_dqm}, {31'd0, exp_dqm[cyc]});
            end
        end
    end

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            req_valid = 1'b0;
        end
    endtask

    // driver: presents one request and pushes the expected pin pattern
    task automatic issue(input logic [2:0] op, input int b, input logic [11:0] row,
                         input logic [8:0] col, input logic ap,
                         input logic [11:0] mode, input logic [3:0] bm,
                         input string tag);
        exp_t e;
        logic ok;
        int   c;
        @(negedge clk);
        req_valid = 1'b1; req_op = op; req_bank = 2'(b); req_row = row;
        req_col = col; req_ap = ap; req_mode = mode; req_bmask = bm;
        c = cyc + 1;
        case (op)
            3'd0:       ok = !m_pd && !m_open[b];
            3'd1, 3'd2: ok = !m_pd && m_open[b] && (m_row[b] == row);
            3'd7:       ok = m_pd;
            default:    ok = !m_pd;
        endcase
        e = '{cyc: c, cmd: 4'hF, ba: 2'd0, addr: 12'd0, err: !ok, tag: tag};
        if (ok) begin
            case (op)
                3'd0: begin
                    e.cmd = 4'b0011; e.ba = 2'(b); e.addr = row;
                    m_open[b] = 1'b1; m_row[b] = row;
                end
                3'd1, 3'd2: begin
                    e.cmd = (op == 3'd1) ? 4'b0101 : 4'b0100;
                    e.ba = 2'(b);
                    e.addr = {1'b0, ap, 1'b0, col};
                    if (ap) m_open[b] = 1'b0;
                    for (int i = 0; i < BL; i++) begin
                        if (bm[i]) begin
                            int t;
                            t = (op == 3'd2) ? c + i : c + CL - 2 + i;
                            exp_dqm[t] = 1'b1;
                            dqm_tag[t] = (op == 3'd2) ? "R7" : "R8";
                        end
                    end
                end
                3'd3: begin
                    e.cmd = 4'b0010; e.ba = 2'(b); m_open[b] = 1'b0;
                end
                3'd4: begin
                    e.cmd = 4'b0010; e.addr = 12'h400;
                    for (int i = 0; i < 4; i++) m_open[i] = 1'b0;
                end
                3'd5: begin
                    e.cmd = 4'b0000; e.addr = mode;
                end
                3'd6: begin m_pd = 1'b1; m_cke = 1'b0; end
                default: begin m_pd = 1'b0; m_cke = 1'b1; end
            endcase
        end
        sb.push_back(e);
    endtask

    initial begin
        #(20 * 20000);
        tests++; fails++;
        $display("FAIL R2 watchdog expired: actual=running expected=finished");
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        for (int i = 0; i < 4; i++) begin m_open[i] = 1'b0; m_row[i] = 12'd0; end
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R1: pin state held during reset
        chk("R1", "reset cmd", {28'd0, sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n}, 32'hF);
        chk("R1", "reset cke", {31'd0, sd_cke}, 32'd1);
        chk("R1", "reset dqm", {31'd0, sd_dqm}, 32'd0);
        chk("R1", "reset err", {31'd0, req_err}, 32'd0);
        rst_n = 1'b1;
        mon_on = 1'b1;
        idle(2);
        issue(3'd1, 3, 12'h000, 9'h001, 1'b0, 12'h0, 4'h0, "R1");    // all closed
        issue(3'd0, 0, 12'h123, 9'h000, 1'b0, 12'h0, 4'h0, "R3");
        issue(3'd0, 0, 12'h123, 9'h000, 1'b0, 12'h0, 4'h0, "R6");    // already open
        issue(3'd1, 1, 12'h4FF, 9'h000, 1'b0, 12'h0, 4'h0, "R6");    // closed bank
        issue(3'd0, 1, 12'h4FF, 9'h000, 1'b0, 12'h0, 4'h0, "R3");    // A10 set in row
        issue(3'd2, 0, 12'h123, 9'h1A5, 1'b0, 12'h0, 4'b0101, "R7");
        issue(3'd1, 0, 12'h124, 9'h010, 1'b0, 12'h0, 4'h0, "R6");    // wrong row
        idle(3);
        issue(3'd1, 1, 12'h4FF, 9'h0FF, 1'b1, 12'h0, 4'b1001, "R8");
        issue(3'd1, 1, 12'h4FF, 9'h0FF, 1'b0, 12'h0, 4'h0, "R4");    // closed by ap
        idle(6);
        issue(3'd2, 0, 12'h123, 9'h002, 1'b0, 12'h0, 4'b1000, "R7");
        issue(3'd1, 0, 12'h123, 9'h003, 1'b0, 12'h0, 4'b0001, "R8");
        idle(6);
        issue(3'd3, 0, 12'h000, 9'h000, 1'b0, 12'h0, 4'h0, "R5");
        issue(3'd2, 0, 12'h123, 9'h004, 1'b0, 12'h0, 4'hF, "R5");    // closed now
        issue(3'd0, 2, 12'h005, 9'h000, 1'b0, 12'h0, 4'h0, "R3");
        issue(3'd0, 3, 12'h007, 9'h000, 1'b0, 12'h0, 4'h0, "R3");
        issue(3'd4, 1, 12'h000, 9'h000, 1'b0, 12'h0, 4'h0, "R5");
        issue(3'd1, 2, 12'h005, 9'h000, 1'b0, 12'h0, 4'h0, "R5");    // all closed
        issue(3'd1, 3, 12'h007, 9'h000, 1'b0, 12'h0, 4'h0, "R5");
        issue(3'd5, 0, 12'h000, 9'h000, 1'b0, 12'h033, 4'h0, "R5");
        issue(3'd0, 0, 12'h001, 9'h000, 1'b0, 12'h0, 4'h0, "R3");
        idle(4);
        issue(3'd7, 0, 12'h000, 9'h000, 1'b0, 12'h0, 4'h0, "R9");    // exit while up
        issue(3'd6, 0, 12'h000, 9'h000, 1'b0, 12'h0, 4'h0, "R9");
        idle(2);
        issue(3'd1, 0, 12'h001, 9'h003, 1'b0, 12'h0, 4'h0, "R9");    // refused in pd
        issue(3'd6, 0, 12'h000, 9'h000, 1'b0, 12'h0, 4'h0, "R9");
        issue(3'd7, 0, 12'h000, 9'h000, 1'b0, 12'h0, 4'h0, "R9");
        idle(1);
        issue(3'd1, 0, 12'h001, 9'h1FF, 1'b0, 12'h0, 4'b1111, "R8"); // still open
        idle(10);
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule